// File: doc/BRIEF.md
# Test Pattern Sequencer with Nested Loops

The block walks through a loadable program of step words and tells the pattern and timing logic which step to apply in each tester cycle. It advances by one step on every cycle-start tick. On each such tick it presents the current step address, the timing-set number held in that step, and a one-cycle sync pulse. A second sync pulse marks the first step after a start. Program flow comes from the opcode of each step: plain advance, unconditional or conditional jump, loop end, subroutine call and return, pause, and halt. Sixteen loop counters allow nested loops, and an eight-entry stack holds return addresses.

Conditions come from four test inputs. Input 0 is the internal data-sense flag and inputs 1 to 3 are external triggers. Each input can be set to level or rising-edge sensitivity. An external halt input ends the run at once. An external break input holds the sequence where it is while it is high. A stack fault stops the run and raises an error flag until the next start.

The controller has four states. `ST_IDLE` waits for a start. `ST_RUN` emits steps. `ST_PAUSE` re-emits a paused step until its condition holds. `ST_FAULT` holds after a stack error. The transitions are: start (IDLE or FAULT to RUN); pause-wait (RUN to PAUSE); pause-release (PAUSE to RUN); halt-op and halt-input (RUN or PAUSE to IDLE); stack-fault (RUN or PAUSE to FAULT).

Top module: `pattern_sequencer`

## Requirements
- R1: After reset the block is idle: `idle`=1, `active`=0, `err`=0, and both sync outputs are low. A `start` pulse while idle or faulted begins the run at step 0. Start clears the loop counters, the stack and `err`, and is ignored while the block is running.
- R2: Each step word is `{op[2:0], target[ADDR_W], loop_idx[4], count[16], test_sel[2], tset[8]}`, most significant field first. On a clock edge where `step_tick` is high and the block is running, the registered outputs take the values of the current step: `step_idx` becomes its address and `tset_idx` its timing set. `step_sync` is high for the following cycle. `seq_sync` is also high for that cycle, but only on the first step emitted after a start.
- R3: Opcode 0 (advance) moves to address+1. Opcode 1 (jump) moves to `target`.
- R4: Opcode 3 (loop end) with count n>0 sends flow back to `target` n−1 times, so the body from `target` to this step runs n times; then flow falls through. The counter chosen by `loop_idx` returns to zero when the loop exits, so an enclosing loop can run the inner loop again for its full count.
- R5: A loop end with count 0 always branches back to `target` and never exits.
- R6: Opcode 4 (call) pushes address+1 and jumps to `target`. Opcode 5 (return) pops the top address and moves there. Up to 8 calls may be nested.
- R7: A call with 8 entries already on the stack, or a return with an empty stack, emits that step and then enters `ST_FAULT`: `err`=1, `idle`=1, `active`=0.
- R8: Opcode 2 (conditional jump) moves to `target` when the selected test input holds, otherwise to address+1. In level mode the input holds when it is currently high.
- R9: With `test_edge[i]`=1, input i holds only after a rising edge seen while edge mode is on. The edge is latched until a taken conditional jump or a released pause that selects input i uses it up. A high level with no new edge does not count.
- R10: Opcode 6 (pause) re-emits the same step on every tick while its selected input does not hold, with `active` staying 1. On the first tick where the input holds, the step is emitted once more and flow moves to address+1.
- R11: Opcode 7 (halt) emits its step and then returns to `ST_IDLE`.
- R12: `halt_in` high while running returns the block to idle on that edge, without emitting a step. While `break_in` is high, ticks are ignored and no step is emitted. Flow resumes from the same step once `break_in` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_we | input | 1 | Program write enable |
| prog_addr | input | ADDR_W | Program write address |
| prog_data | input | WORD_W | Step word to write |
| start | input | 1 | Begin a run at step 0 |
| step_tick | input | 1 | Cycle-start tick |
| halt_in | input | 1 | External stop |
| break_in | input | 1 | External hold of advance |
| data_sense | input | 1 | Internal data-sense flag (test input 0) |
| ext_trig | input | NTEST-1 | External triggers (test inputs 1 and up) |
| test_edge | input | NTEST | Per-input edge-mode select |
| step_idx | output | ADDR_W | Address of the emitted step |
| tset_idx | output | TS_W | Timing set of the emitted step |
| step_sync | output | 1 | Pulse for each emitted step |
| seq_sync | output | 1 | Pulse with the first step after start |
| active | output | 1 | Running or paused |
| idle | output | 1 | Not running |
| err | output | 1 | Stack fault seen |

## Verification
The hardest situations to reach are the stack limits. A ninth nested call and a return on an empty stack only occur after a chain of calls that must first unwind correctly. The bench therefore builds call chains of every depth from 1 to 9 out of paired call and return steps. Each chain ends in an underflow or, at depth 9, an overflow, so both faults are reached as the natural end of a correct run. Counter reload is reached the same way: an inner loop inside an outer loop is swept over several counts for each loop, and an inner count that failed to reload would show as a short second pass.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CJMP  = 3'd2,
        OP_LOOP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5,
        OP_PAUSE = 3'd6,
        OP_HALT  = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_FAULT
    } seq_state_e;
endpackage

// File: rtl/seq_store.sv
module seq_store #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 43
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/seq_testsel.sv
module seq_testsel #(
    parameter int NTEST  = 4,
    parameter int TSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTEST-1:0]  test_in,
    input  logic [NTEST-1:0]  edge_mode,
    input  logic [TSEL_W-1:0] sel,
    input  logic              consume,
    output logic              cond
);
    logic [NTEST-1:0] prev;
    logic [NTEST-1:0] pend;
    logic [NTEST-1:0] rise;

    assign rise = test_in & ~prev;
    assign cond = edge_mode[sel] ? pend[sel] : test_in[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= test_in;
    end

    for (genvar g = 0; g < NTEST; g++) begin : g_pend
        logic flag;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag <= 1'b0;
            else        flag <= edge_mode[g] &&
                                ((flag && !(consume && sel == TSEL_W'(g))) || rise[g]);
        end
        assign pend[g] = flag;
    end

    // R9
    edge_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume && edge_mode[sel] |-> pend[sel]);
endmodule

// File: rtl/seq_loopctl.sv
module seq_loopctl #(
    parameter int NLOOP  = 16,
    parameter int CNT_W  = 16,
    parameter int LIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fire,
    input  logic [LIDX_W-1:0] idx,
    input  logic [CNT_W-1:0]  count,
    output logic              take_back
);
    logic [NLOOP-1:0][CNT_W-1:0] cnt;
    logic last;

    assign last      = (count != '0) && (cnt[idx] == count - 1'b1);
    assign take_back = !last;

    for (genvar g = 0; g < NLOOP; g++) begin : g_ctr
        logic [CNT_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                r <= '0;
            else if (clr)              r <= '0;
            else if (fire && idx == LIDX_W'(g)) begin
                if (last)              r <= '0;
                else if (count != '0)  r <= r + 1'b1;
            end
        end
        assign cnt[g] = r;

        // R4
        loop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire && idx == LIDX_W'(g) && count != '0 |-> r < count);
    end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   top_i;

    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);
    assign top_i = sp - 1'b1;
    assign dout  = mem[top_i[IDX_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp <= '0;
        else if (clr)  sp <= '0;
        else if (push) sp <= sp + 1'b1;
        else if (pop)  sp <= sp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push) mem[sp[IDX_W-1:0]] <= din;
    end

    // R7
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int NLOOP   = 16,
    parameter int CNT_W   = 16,
    parameter int STACK_D = 8,
    parameter int NTEST   = 4,
    parameter int TS_W    = 8,
    localparam int LIDX_W = $clog2(NLOOP),
    localparam int TSEL_W = $clog2(NTEST),
    localparam int WORD_W = 3 + ADDR_W + LIDX_W + CNT_W + TSEL_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              start,
    input  logic              step_tick,
    input  logic              halt_in,
    input  logic              break_in,
    input  logic              data_sense,
    input  logic [NTEST-2:0]  ext_trig,
    input  logic [NTEST-1:0]  test_edge,
    output logic [ADDR_W-1:0] step_idx,
    output logic [TS_W-1:0]   tset_idx,
    output logic              step_sync,
    output logic              seq_sync,
    output logic              active,
    output logic              idle,
    output logic              err
);
    localparam int F_SEL  = TS_W;
    localparam int F_CNT  = F_SEL + TSEL_W;
    localparam int F_LIDX = F_CNT + CNT_W;
    localparam int F_TGT  = F_LIDX + LIDX_W;
    localparam int F_OP   = F_TGT + ADDR_W;

    seq_state_e        state, nstate;
    logic [ADDR_W-1:0] pc, pc_nxt, pc_inc, ret_addr;
    logic [WORD_W-1:0] word;
    seq_op_e           op;
    logic              running, emit, first, cond, take_back, full, empty;
    logic              push, pop, loop_fire, consume, clr;

    assign op      = seq_op_e'(word[F_OP +: 3]);
    assign pc_inc  = pc + 1'b1;
    assign running = (state == ST_RUN) || (state == ST_PAUSE);
    assign emit    = running && step_tick && !break_in && !halt_in;

    seq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .wr_en(prog_we), .wr_addr(prog_addr), .wr_data(prog_data),
        .rd_addr(pc), .rd_data(word));

    seq_testsel #(.NTEST(NTEST), .TSEL_W(TSEL_W)) u_test (
        .clk(clk), .rst_n(rst_n), .test_in({ext_trig, data_sense}),
        .edge_mode(test_edge), .sel(word[F_SEL +: TSEL_W]),
        .consume(consume), .cond(cond));

    seq_loopctl #(.NLOOP(NLOOP), .CNT_W(CNT_W), .LIDX_W(LIDX_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(loop_fire),
        .idx(word[F_LIDX +: LIDX_W]), .count(word[F_CNT +: CNT_W]),
        .take_back(take_back));

    seq_stack #(.DEPTH(STACK_D), .DATA_W(ADDR_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
        .din(pc_inc), .dout(ret_addr), .full(full), .empty(empty));

    // Next-state and flow decisions
    always_comb begin
        nstate    = state;
        pc_nxt    = pc;
        push      = 1'b0;
        pop       = 1'b0;
        loop_fire = 1'b0;
        consume   = 1'b0;
        clr       = 1'b0;
        unique case (state)
            ST_IDLE, ST_FAULT: begin
                if (start) begin
                    nstate = ST_RUN;
                    pc_nxt = '0;
                    clr    = 1'b1;
                end
            end
            ST_RUN, ST_PAUSE: begin
                if (halt_in) begin
                    nstate = ST_IDLE;
                end else if (emit) begin
                    nstate = ST_RUN;
                    unique case (op)
                        OP_STEP: pc_nxt = pc_inc;
                        OP_JUMP: pc_nxt = word[F_TGT +: ADDR_W];
                        OP_CJMP: begin
                            consume = cond;
                            pc_nxt  = cond ? word[F_TGT +: ADDR_W] : pc_inc;
                        end
                        OP_LOOP: begin
                            loop_fire = 1'b1;
                            pc_nxt    = take_back ? word[F_TGT +: ADDR_W] : pc_inc;
                        end
                        OP_CALL: begin
                            if (full) nstate = ST_FAULT;
                            else begin
                                push   = 1'b1;
                                pc_nxt = word[F_TGT +: ADDR_W];
                            end
                        end
                        OP_RET: begin
                            if (empty) nstate = ST_FAULT;
                            else begin
                                pop    = 1'b1;
                                pc_nxt = ret_addr;
                            end
                        end
                        OP_PAUSE: begin
                            if (cond) begin
                                consume = 1'b1;
                                pc_nxt  = pc_inc;
                            end else begin
                                nstate = ST_PAUSE;
                            end
                        end
                        OP_HALT: nstate = ST_IDLE;
                        default: nstate = ST_RUN;
                    endcase
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else begin
            state <= nstate;
            pc    <= pc_nxt;
        end
    end

    // Registered step outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_idx  <= '0;
            tset_idx  <= '0;
            step_sync <= 1'b0;
            seq_sync  <= 1'b0;
            first     <= 1'b0;
        end else begin
            step_sync <= emit;
            seq_sync  <= emit && first;
            if (emit) begin
                step_idx <= pc;
                tset_idx <= word[TS_W-1:0];
            end
            if (!running && start) first <= 1'b1;
            else if (emit)         first <= 1'b0;
        end
    end

    assign active = running;
    assign idle   = !running;
    assign err    = (state == ST_FAULT);

    // R2
    step_sync_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_sync |-> $past(step_tick));
    // R2
    seq_sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_sync |-> step_sync);
    // R12
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in && active |=> idle);
    // R12
    break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_in |=> !step_sync);
    // R7
    err_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(active));
endmodule

// File: tb/sim_pattern_sequencer.sv
module sim_pattern_sequencer;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;
    localparam int WORD_W = 43;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_we = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [WORD_W-1:0] prog_data = '0;
    logic              start = 1'b0, step_tick = 1'b0, halt_in = 1'b0, break_in = 1'b0;
    logic              data_sense = 1'b0;
    logic [2:0]        ext_trig = '0;
    logic [3:0]        test_edge = '0;
    logic [ADDR_W-1:0] step_idx;
    logic [7:0]        tset_idx;
    logic              step_sync, seq_sync, active, idle, err;

    int nvec = 0;
    int nbad = 0;

    pattern_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .start(start), .step_tick(step_tick),
        .halt_in(halt_in), .break_in(break_in), .data_sense(data_sense),
        .ext_trig(ext_trig), .test_edge(test_edge), .step_idx(step_idx),
        .tset_idx(tset_idx), .step_sync(step_sync), .seq_sync(seq_sync),
        .active(active), .idle(idle), .err(err));

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] mk(int op, int tgt, int lidx, int cnt, int sel, int ts);
        return {op[2:0], tgt[ADDR_W-1:0], lidx[3:0], cnt[15:0], sel[1:0], ts[7:0]};
    endfunction

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(int a, logic [WORD_W-1:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a[ADDR_W-1:0]; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R1 err cleared by start", err, 0);
    endtask

    task automatic tick();
        @(negedge clk); step_tick = 1'b1;
        @(negedge clk); step_tick = 1'b0;
    endtask

    task automatic exp_step(int idx, int first, string tag);
        tick();
        chk({tag, " step_sync"}, step_sync, 1);
        chk({tag, " step_idx"}, step_idx, idx);
        chk("R2 seq_sync", seq_sync, first);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle", idle, 1); chk("R1 active", active, 0);
        chk("R1 err", err, 0);   chk("R1 step_sync", step_sync, 0);
        chk("R1 seq_sync", seq_sync, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 nested loop sweep: outer k=0 count m, inner k=1 count n
        for (int m = 1; m <= 3; m++) begin
            for (int n = 1; n <= 4; n++) begin
                load(0, mk(0, 0, 0, 0, 0, 5));
                load(1, mk(0, 0, 0, 0, 0, 6));
                load(2, mk(3, 1, 1, n, 0, 0));
                load(3, mk(3, 0, 0, m, 0, 0));
                load(4, mk(7, 0, 0, 0, 0, 0));
                go();
                for (int o = 0; o < m; o++) begin
                    exp_step(0, (o == 0) ? 1 : 0, "R3");
                    chk("R2 tset", tset_idx, 5);
                    for (int i = 0; i < n; i++) begin
                        exp_step(1, 0, "R4 inner");
                        exp_step(2, 0, "R4 inner end");
                    end
                    exp_step(3, 0, "R4 outer end");
                end
                exp_step(4, 0, "R11");
                chk("R11 idle", idle, 1);
                chk("R11 active", active, 0);
            end
        end

        // R6 plain call/return, R3 jump
        load(0, mk(4, 5, 0, 0, 0, 0));
        load(1, mk(4, 5, 0, 0, 0, 0));
        load(2, mk(1, 8, 0, 0, 0, 0));
        load(5, mk(0, 0, 0, 0, 0, 9));
        load(6, mk(5, 0, 0, 0, 0, 0));
        load(8, mk(7, 0, 0, 0, 0, 0));
        go();
        exp_step(0, 1, "R6"); exp_step(5, 0, "R6");
        chk("R2 tset", tset_idx, 9);
        exp_step(6, 0, "R6"); exp_step(1, 0, "R6");
        exp_step(5, 0, "R6"); exp_step(6, 0, "R6");
        exp_step(2, 0, "R3 jump"); exp_step(8, 0, "R3 jump");
        chk("R11 idle", idle, 1);

        // R6/R7 call chain depth sweep: depth 9 overflows, others underflow
        for (int d = 1; d <= 9; d++) begin
            for (int i = 0; i < d; i++) begin
                load(2*i, mk(4, 2*i+2, 0, 0, 0, 0));
                load(2*i+1, mk(5, 0, 0, 0, 0, 0));
            end
            load(2*d, mk(5, 0, 0, 0, 0, 0));
            go();
            if (d <= 8) begin
                for (int i = 0; i <= d; i++) exp_step(2*i, (i == 0) ? 1 : 0, "R6 call");
                for (int i = d; i >= 1; i--) exp_step(2*i-1, 0, "R6 ret");
                chk("R7 underflow err", err, 1);
            end else begin
                for (int i = 0; i < 9; i++) exp_step(2*i, (i == 0) ? 1 : 0, "R6 call");
                chk("R7 overflow err", err, 1);
            end
            chk("R7 idle", idle, 1);
            chk("R7 active", active, 0);
        end

        // R8 level-mode conditional jump over each select
        load(0, mk(0, 0, 0, 0, 0, 0));
        load(1, mk(7, 0, 0, 0, 0, 0));
        load(3, mk(7, 0, 0, 0, 0, 0));
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                load(0, mk(2, 3, 0, 0, s, 0));
                @(negedge clk);
                {ext_trig, data_sense} = (v != 0) ? (4'b0001 << s) : ~(4'b0001 << s);
                go();
                exp_step(0, 1, "R8");
                exp_step((v != 0) ? 3 : 1, 0, "R8 branch");
            end
        end

        // R9 edge mode on input 2
        @(negedge clk);
        {ext_trig, data_sense} = 4'b0100;
        @(negedge clk);
        test_edge = 4'b0100;
        load(0, mk(2, 3, 0, 0, 2, 0));
        go();
        exp_step(0, 1, "R9"); exp_step(1, 0, "R9 level ignored");
        @(negedge clk); ext_trig[1] = 1'b0;
        @(negedge clk); ext_trig[1] = 1'b1;
        @(negedge clk); ext_trig[1] = 1'b0;
        go();
        exp_step(0, 1, "R9"); exp_step(3, 0, "R9 edge taken");
        go();
        exp_step(0, 1, "R9"); exp_step(1, 0, "R9 edge consumed");
        test_edge = 4'b0000;

        // R10 pause on input 3, level mode
        load(0, mk(6, 0, 0, 0, 3, 0));
        @(negedge clk); ext_trig[2] = 1'b0;
        go();
        for (int i = 0; i < 3; i++) begin
            exp_step(0, (i == 0) ? 1 : 0, "R10 hold");
            chk("R10 active", active, 1);
        end
        @(negedge clk); ext_trig[2] = 1'b1;
        exp_step(0, 0, "R10 release");
        exp_step(1, 0, "R10 advance");
        @(negedge clk); ext_trig[2] = 1'b0;

        // R5 continuous loop, R12 break and halt
        load(0, mk(0, 0, 0, 0, 0, 0));
        load(1, mk(3, 0, 2, 0, 0, 0));
        go();
        for (int i = 0; i < 40; i++) exp_step(i % 2, (i == 0) ? 1 : 0, "R5");
        @(negedge clk); break_in = 1'b1;
        tick();
        chk("R12 break no sync", step_sync, 0);
        chk("R12 break idx", step_idx, 1);
        tick();
        chk("R12 break no sync", step_sync, 0);
        @(negedge clk); break_in = 1'b0;
        exp_step(0, 0, "R12 resume");
        @(negedge clk); halt_in = 1'b1;
        @(negedge clk); halt_in = 1'b0;
        chk("R12 halt idle", idle, 1);
        chk("R12 halt active", active, 0);
        chk("R12 halt no step", step_sync, 0);
        tick();
        chk("R1 ticks ignored idle", step_sync, 0);

        report();
    end
endmodule